// File: doc/BRIEF.md
# Serial Framer and Byte Aligner

This block sits directly behind a recovered serial data path of an optical line interface. It samples one data bit on each rising edge of the bit clock and packs eight bits at a time into a parallel byte. It also drives a byte clock that runs at one eighth of the bit rate, so a 622.08 Mb/s line gives 77.76 MHz and a 155.52 Mb/s line gives 19.44 MHz. Bits enter the byte most significant first. All eight output bits move together at the falling edge of the byte clock.

A downstream device that has lost frame raises the level-sensitive `oof_req` input. While it stays high, the block compares the most recent 48 received bits against the frame alignment word after every bit. The frame alignment word is three 0xF6 bytes followed by three 0x28 bytes. When the word matches at any bit offset, the byte boundary moves so that the third 0x28 byte is the byte completed on that edge. The byte after it then comes out fully aligned. A frame pulse marks that third 0x28 byte for one byte period. While `oof_req` is low, the current boundary is kept and no pulse is produced.

Top module: `sonet_byte_aligner`

## Requirements
- R1: While `rst_n` is low, `par_byte` is 0x00, `frame_pulse` is 0 and `byte_clk` is 0.
- R2: After reset, the first eight sampled bits form the first byte. The first bit of each byte lands on `par_byte[7]` and the eighth bit lands on `par_byte[0]`.
- R3: `byte_clk` is low for the first four bit periods after a byte update and high for the next four. Its high phase never lasts more than four bit periods.
- R4: `par_byte` and `frame_pulse` change only on byte-update edges. Outside a realignment, a change of `par_byte` coincides with a falling edge of `byte_clk`.
- R5: While `oof_req` is high, an edge that completes the bit sequence F6 F6 F6 28 28 28 (MSB first, at any offset) is a byte update. On that update, `par_byte` shows 0x28 and `frame_pulse` goes high for exactly eight bit periods.
- R6: After a match, the next eight bits form the next output byte, so payload bytes appear unchanged on `par_byte`.
- R7: While `oof_req` is low, the framing sequence at any offset neither moves the byte boundary nor raises `frame_pulse`.
- R8: While `oof_req` is high, every framing sequence produces a pulse, including one that already sits on the current boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Recovered bit clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit | input | 1 | Serial line data bit |
| oof_req | input | 1 | Level request to hunt for frame alignment |
| par_byte | output | 8 | Parallel byte, MSB is the earliest bit |
| byte_clk | output | 1 | Bit clock divided by eight, falls when `par_byte` updates |
| frame_pulse | output | 1 | One byte period high on the third 0x28 byte of a detected frame |

## Verification
A wrong bit phase shows at once as rotated or mixed bytes on `par_byte` within one byte period. It also shifts the position of the `byte_clk` falling edge against the data. A wrong match or gating decision either loses the pulse or fires it with `oof_req` low, and the next payload byte then comes out misaligned eight bit clocks later. The bench compares every output on every bit against a bit-level model. It also checks payload bytes directly after frames sent at random offsets.

// File: rtl/sba_pkg.sv
package sba_pkg;
   typedef logic [7:0] sba_byte_t;
   localparam sba_byte_t SBA_A1_DEF = 8'hF6;
   localparam sba_byte_t SBA_A2_DEF = 8'h28;
   localparam int unsigned SBA_N_A1_DEF = 3;
   localparam int unsigned SBA_N_A2_DEF = 3;
endpackage

// File: rtl/sba_window.sv
module sba_window #(
   parameter int unsigned WIN_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [WIN_W-1:0] win_next
);
   logic [WIN_W-1:0] win_q;

   // newest bit enters at the LSB, oldest leaves at the MSB
   assign win_next = {win_q[WIN_W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= win_next;
   end
endmodule

// File: rtl/sba_frame_match.sv
module sba_frame_match #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned N_A1   = 3,
   parameter int unsigned N_A2   = 3,
   parameter logic [BYTE_W-1:0] A1_CODE = 8'hF6,
   parameter logic [BYTE_W-1:0] A2_CODE = 8'h28,
   localparam int unsigned N_LANE = N_A1 + N_A2,
   localparam int unsigned WIN_W  = BYTE_W * N_LANE
) (
   input  logic [WIN_W-1:0] win,
   output logic             hit
);
   logic [N_LANE-1:0] lane_ok;

   // lane 0 is the oldest byte, held at the top of the window
   for (genvar i = 0; i < N_LANE; i++) begin : g_lane
      localparam int unsigned TOP = WIN_W - 1 - i * BYTE_W;
      if (i < N_A1) begin : g_first
         assign lane_ok[i] = (win[TOP -: BYTE_W] == A1_CODE);
      end else begin : g_second
         assign lane_ok[i] = (win[TOP -: BYTE_W] == A2_CODE);
      end
   end

   assign hit = &lane_ok;
endmodule

// File: rtl/sba_phase_ctr.sv
module sba_phase_ctr #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned PH_W = $clog2(BYTE_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync,
   output logic byte_done,
   output logic half_hi
);
   logic [PH_W-1:0] ph_q;

   assign byte_done = sync | (ph_q == PH_W'(BYTE_W - 1));
   assign half_hi   = ph_q[PH_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ph_q <= '0;
      else if (byte_done) ph_q <= '0;
      else                ph_q <= ph_q + 1'b1;
   end
endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned N_A1   = sba_pkg::SBA_N_A1_DEF,
   parameter int unsigned N_A2   = sba_pkg::SBA_N_A2_DEF,
   parameter logic [BYTE_W-1:0] A1_CODE = sba_pkg::SBA_A1_DEF,
   parameter logic [BYTE_W-1:0] A2_CODE = sba_pkg::SBA_A2_DEF,
   localparam int unsigned WIN_W = BYTE_W * (N_A1 + N_A2)
) (
   input  logic              bit_clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   input  logic              oof_req,
   output logic [BYTE_W-1:0] par_byte,
   output logic              byte_clk,
   output logic              frame_pulse
);
   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_width
      $error("BYTE_W must be a power of two, at least 2");
   end
   if (N_A1 < 1 || N_A2 < 1) begin : g_bad_count
      $error("framing word needs at least one byte of each kind");
   end
   if (A1_CODE == A2_CODE) begin : g_bad_codes
      $error("the two framing byte codes must differ");
   end

   logic [WIN_W-1:0]  win_next;
   logic              hit;
   logic              sync;
   logic              byte_done;
   logic [BYTE_W-1:0] par_q;
   logic              fp_q;

   sba_window #(.WIN_W(WIN_W)) u_window (
      .clk      (bit_clk),
      .rst_n    (rst_n),
      .din      (ser_bit),
      .win_next (win_next)
   );

   sba_frame_match #(
      .BYTE_W  (BYTE_W),
      .N_A1    (N_A1),
      .N_A2    (N_A2),
      .A1_CODE (A1_CODE),
      .A2_CODE (A2_CODE)
   ) u_match (
      .win (win_next),
      .hit (hit)
   );

   // hunting is allowed only while the request level is high
   assign sync = hit & oof_req;

   sba_phase_ctr #(.BYTE_W(BYTE_W)) u_phase (
      .clk       (bit_clk),
      .rst_n     (rst_n),
      .sync      (sync),
      .byte_done (byte_done),
      .half_hi   (byte_clk)
   );

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= '0;
         fp_q  <= 1'b0;
      end else if (byte_done) begin
         par_q <= win_next[BYTE_W-1:0];
         fp_q  <= sync;
      end
   end

   assign par_byte    = par_q;
   assign frame_pulse = fp_q;
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
   parameter int unsigned BYTE_W = 8,
   parameter logic [BYTE_W-1:0] A2_CODE = 8'h28
) (
   input logic              bit_clk,
   input logic              rst_n,
   input logic              oof_req,
   input logic [BYTE_W-1:0] par_byte,
   input logic              byte_clk,
   input logic              frame_pulse
);
   logic [7:0] fp_run;
   logic [7:0] hi_run;

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         fp_run <= '0;
         hi_run <= '0;
      end else begin
         fp_run <= frame_pulse ? ((fp_run == 8'hFF) ? fp_run : fp_run + 1'b1) : '0;
         hi_run <= byte_clk ? ((hi_run == 8'hFF) ? hi_run : hi_run + 1'b1) : '0;
      end
   end

   // R5
   fp_width_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      $fell(frame_pulse) |-> fp_run == 8'(BYTE_W));
   // R5
   fp_max_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      fp_run <= 8'(BYTE_W));
   // R5
   fp_a2_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      $rose(frame_pulse) |-> par_byte == A2_CODE);
   // R7
   fp_needs_oof_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      $rose(frame_pulse) |-> $past(oof_req));
   // R4
   data_on_fall_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (!$stable(par_byte) && !frame_pulse) |-> $fell(byte_clk));
   // R3
   bclk_hi_max_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      hi_run <= 8'(BYTE_W / 2));
   // R3
   bclk_hi_full_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      ($fell(byte_clk) && !frame_pulse) |-> hi_run == 8'(BYTE_W / 2));
endmodule

bind sonet_byte_aligner sba_checker #(
   .BYTE_W  (BYTE_W),
   .A2_CODE (A2_CODE)
) u_sba_checker (
   .bit_clk     (bit_clk),
   .rst_n       (rst_n),
   .oof_req     (oof_req),
   .par_byte    (par_byte),
   .byte_clk    (byte_clk),
   .frame_pulse (frame_pulse)
);

// File: tb/sonet_byte_aligner_bench.sv
module sonet_byte_aligner_bench;
   localparam logic [47:0] SYNC_WORD = 48'hF6F6_F628_2828;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_bit = 1'b0;
   logic       oof = 1'b0;
   logic [7:0] par;
   logic       bclk;
   logic       fp;

   int n_chk = 0;
   int n_bad = 0;
   int rises = 0;
   int exp_rises = 0;
   logic fp_prev = 1'b0;

   logic [47:0] m_hist = '0;
   int          m_k = 0;
   logic [7:0]  m_par = '0;
   logic        m_fp = 1'b0;

   always #2 clk = ~clk;

   sonet_byte_aligner u_sonet_byte_aligner (
      .bit_clk     (clk),
      .rst_n       (rst_n),
      .ser_bit     (ser_bit),
      .oof_req     (oof),
      .par_byte    (par),
      .byte_clk    (bclk),
      .frame_pulse (fp)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one bit at a falling edge, model it, then compare at the next falling edge
   task automatic push_bit(input logic b);
      logic [47:0] nh;
      nh = {m_hist[46:0], b};
      ser_bit = b;
      if (oof && nh == SYNC_WORD) begin
         m_par = nh[7:0]; m_fp = 1'b1; m_k = 0; exp_rises++;
      end else if (m_k == 7) begin
         m_par = nh[7:0]; m_fp = 1'b0; m_k = 0;
      end else begin
         m_k++;
      end
      m_hist = nh;
      @(negedge clk);
      check("R4 par_byte per bit", int'(par), int'(m_par));
      check("R5 frame_pulse per bit", int'(fp), int'(m_fp));
      check("R3 byte_clk per bit", int'(bclk), (m_k >= 4) ? 1 : 0);
      if (fp && !fp_prev) rises++;
      fp_prev = fp;
   endtask

   task automatic push_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) push_bit(v[i]);
   endtask

   task automatic push_sync();
      for (int i = 47; i >= 0; i--) push_bit(SYNC_WORD[i]);
   endtask

   task automatic push_noise(input int n);
      for (int i = 0; i < n; i++) push_bit(1'($urandom));
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] pb;
      int r0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 par_byte in reset", int'(par), 0);
      check("R1 frame_pulse in reset", int'(fp), 0);
      check("R1 byte_clk in reset", int'(bclk), 0);
      rst_n = 1'b1;

      // R2 boundary at offset 0 and MSB first
      push_byte(8'h80);
      check("R2 msb first", int'(par), 8'h80);
      push_byte(8'h01);
      check("R2 lsb last", int'(par), 8'h01);
      for (int j = 0; j < 6; j++) begin
         pb = 8'($urandom);
         push_byte(pb);
         check("R2 byte from reset boundary", int'(par), int'(pb));
      end

      // R7 framing at another offset with the request low
      push_noise(3);
      push_sync();
      push_noise(5);
      check("R7 no pulse with oof low", rises, 0);
      push_byte(8'hA5);
      check("R7 boundary kept", int'(par), 8'hA5);

      // R5, R6 hunting at random offsets
      oof = 1'b1;
      for (int f = 0; f < 24; f++) begin
         r0 = int'($urandom_range(0, 7));
         if (f % 6 == 5) r0 = 0;
         push_noise(r0);
         push_sync();
         check("R5 pulse on third A2", int'(fp), 1);
         check("R5 A2 on bus", int'(par), 8'h28);
         for (int j = 0; j < 4; j++) begin
            pb = 8'($urandom);
            push_byte(pb);
            check("R6 payload aligned", int'(par), int'(pb));
            if (j == 0) check("R5 pulse one byte long", int'(fp), 0);
         end
         // R8 an already aligned frame still pulses
         if (f % 4 == 0) begin
            push_sync();
            check("R8 pulse on aligned frame", int'(fp), 1);
            pb = 8'($urandom);
            push_byte(pb);
            check("R8 payload after aligned frame", int'(par), int'(pb));
         end
      end
      check("R8 one pulse per frame", rises, exp_rises);

      // R7 request dropped: boundary frozen
      oof = 1'b0;
      r0 = rises;
      push_noise(5);
      push_sync();
      push_noise(3);
      pb = 8'($urandom);
      push_byte(pb);
      check("R7 no pulse after oof drop", rises, r0);
      push_noise(16);

      summary();
      $finish;
   end
endmodule